// File: doc/BRIEF.md
# Windowed Receive Buffer with Bulk Release

This block holds the bytes that a serial receiver produces in a 1024-byte circular RAM. The host does not pop bytes one at a time. It reads the unreleased bytes in place through a memory window, four bytes per 32-bit read. It then frees a whole batch with one write that gives the number of bytes it consumed. A status word reports the fill count. A request output rises once the fill reaches a programmable level.

The byte stream enters as a valid strobe with an 8-bit data path. The host side is a simple 32-bit register port with a write strobe, a read strobe and a byte address. Read data is registered and appears on the cycle after the read strobe. Address map: status word at 0x000, data window at 0x004 up to but not including 0x400, release register at 0x800, configuration register at 0x808. Any other address reads as zero.

Top module: `rx_window_buf`

## Requirements
- R1: After reset the fill count is 0, the overrun flag is clear, the configuration is all zero and the request output is low, so reads of the status word and of the configuration register return 0.
- R2: Each byte accepted from the input stream adds one to the fill count. The status word shows fill[7:0] in bits 31:24 and fill[9:8] in bits 7:6.
- R3: A read of window address 0x004+4j returns the bytes at positions k = 4j to 4j+3 past the oldest unreleased byte, position k in bits 8(k-4j)+7 : 8(k-4j). The result appears on reg_rdata one cycle after the read strobe. The window covers positions 0 to 1019.
- R4: Window lanes whose position k is at or beyond the fill count read as 0. A write anywhere in the window changes neither the stored bytes nor the fill count.
- R5: Writing N to 0x800 releases min(N, fill) bytes. The oldest-byte pointer advances by that amount modulo 1024 and the fill count drops by the same amount.
- R6: An accepted byte and a release in the same cycle both take effect: the new fill is fill + 1 - released.
- R7: The buffer holds at most 1023 bytes. A byte that arrives while 1023 are held is dropped and sets the sticky overrun flag at status bit 16. Writing a 1 to bit 16 of 0x000 clears the flag, unless a byte is dropped in the same cycle.
- R8: The configuration register at 0x808 holds the request enable in bit 0 and a 3-bit level in bits 22:20, and reads back as written. Reads of unmapped addresses return 0.
- R9: The request output and status bit 1 are high exactly when the enable is set and fill >= 4 << level (level 5 gives 128, level 6 gives 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Data-available request |

## Verification
A corrupted read pointer shows up on the next window read: bytes come back shifted or out of order. This is most visible right after a release that wraps past position 1023. A wrong fill count shows up in the next status read, and in the lanes that read as zero or nonzero at the end of the valid data. It also moves the request output in the same cycle, because the request is derived from the registered fill. Overrun and clamping faults are exposed by deliberately filling the buffer past its capacity and by releasing more bytes than are held.

// File: rtl/rx_window_pkg.sv
package rx_window_pkg;
    localparam logic [11:0] OFS_STATUS  = 12'h000;
    localparam logic [11:0] OFS_WIN_LO  = 12'h004;
    localparam logic [11:0] OFS_WIN_END = 12'h400;
    localparam logic [11:0] OFS_RELEASE = 12'h800;
    localparam logic [11:0] OFS_CFG     = 12'h808;
    localparam int ST_OVR_BIT   = 16;
    localparam int ST_CAUSE_BIT = 1;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_LVL_LSB  = 20;
endpackage

// File: rtl/rx_window_bank.sv
module rx_window_bank #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [7:0] store [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_idx] <= wr_data;
    end

    assign rd_data = store[rd_idx];
endmodule

// File: rtl/rx_window_trig.sv
module rx_window_trig #(
    parameter int PTR_W = 10,
    parameter int LVL_W = 3
) (
    input  logic [PTR_W-1:0] fill,
    input  logic [LVL_W-1:0] level,
    input  logic             enable,
    output logic             hit
);
    localparam int TH_W  = (1 << LVL_W) + 2;
    localparam int CMP_W = (TH_W > PTR_W) ? TH_W : PTR_W;

    logic [CMP_W-1:0] thresh;

    always_comb begin
        thresh = CMP_W'(4) << level;
        hit    = enable && (CMP_W'(fill) >= thresh);
    end
endmodule

// File: rtl/rx_window_buf.sv
module rx_window_buf
    import rx_window_pkg::*;
#(
    parameter int PTR_W = 10,
    parameter int LVL_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int NBANK = 4;
    localparam int IDX_W = PTR_W - 2;
    localparam int DEPTH = 1 << PTR_W;
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] fill;
        logic             ovr;
        logic             ien;
        logic [LVL_W-1:0] lvl;
        logic [31:0]      rdata;
    } state_t;

    state_t s_d, s_q;

    logic             push;
    logic             hit;
    logic [PTR_W-1:0] k_base;
    logic [7:0]       bank_rd [NBANK];
    logic [PTR_W-1:0] fill_q;
    logic             ovr_q;
    logic             ien_q;

    assign fill_q = s_q.fill;
    assign ovr_q  = s_q.ovr;
    assign ien_q  = s_q.ien;

    // window offset of the addressed word, counted from the oldest byte
    assign k_base = {reg_addr[PTR_W-1:2], 2'b00} - PTR_W'(4);
    assign push   = in_valid && (s_q.fill != FULL_LVL);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [1:0]       lane;
        logic [PTR_W-1:0] phys;
        assign lane = 2'(b) - s_q.rptr[1:0];
        assign phys = s_q.rptr + k_base + PTR_W'(lane);
        rx_window_bank #(.IDX_W(IDX_W)) u_bank (
            .clk     (clk),
            .wr_en   (push && (s_q.wptr[1:0] == 2'(b))),
            .wr_idx  (s_q.wptr[PTR_W-1:2]),
            .wr_data (in_data),
            .rd_idx  (phys[PTR_W-1:2]),
            .rd_data (bank_rd[b])
        );
    end

    rx_window_trig #(.PTR_W(PTR_W), .LVL_W(LVL_W)) u_trig (
        .fill   (s_q.fill),
        .level  (s_q.lvl),
        .enable (s_q.ien),
        .hit    (hit)
    );

    logic             sel_status, sel_win, sel_rel, sel_cfg;
    logic [PTR_W-1:0] rel_n;
    logic [31:0]      win_word, st_word, cfg_word, rd_word;
    logic [1:0]       bsel;
    logic [PTR_W-1:0] k_lane;
    logic             ovr_clr;

    always_comb begin
        sel_status = (reg_addr == OFS_STATUS);
        sel_win    = (reg_addr >= OFS_WIN_LO) && (reg_addr < OFS_WIN_END);
        sel_rel    = (reg_addr == OFS_RELEASE);
        sel_cfg    = (reg_addr == OFS_CFG);

        rel_n = '0;
        if (reg_wr && sel_rel) begin
            rel_n = (reg_wdata > 32'(s_q.fill)) ? s_q.fill : reg_wdata[PTR_W-1:0];
        end

        win_word = '0;
        bsel     = '0;
        k_lane   = '0;
        for (int i = 0; i < NBANK; i++) begin
            bsel   = s_q.rptr[1:0] + 2'(i);
            k_lane = k_base + PTR_W'(i);
            if (k_lane < s_q.fill) win_word[8*i +: 8] = bank_rd[bsel];
        end

        st_word = '0;
        st_word[31:24]        = s_q.fill[7:0];
        st_word[7:6]          = s_q.fill[PTR_W-1:8];
        st_word[ST_OVR_BIT]   = s_q.ovr;
        st_word[ST_CAUSE_BIT] = hit;

        cfg_word = '0;
        cfg_word[CFG_EN_BIT]              = s_q.ien;
        cfg_word[CFG_LVL_LSB +: LVL_W]    = s_q.lvl;

        rd_word = '0;
        if (sel_status)   rd_word = st_word;
        else if (sel_win) rd_word = win_word;
        else if (sel_cfg) rd_word = cfg_word;

        ovr_clr = reg_wr && sel_status && reg_wdata[ST_OVR_BIT];

        s_d       = s_q;
        s_d.wptr  = s_q.wptr + PTR_W'(push);
        s_d.rptr  = s_q.rptr + rel_n;
        s_d.fill  = s_q.fill + PTR_W'(push) - rel_n;
        s_d.ovr   = (s_q.ovr && !ovr_clr) || (in_valid && !push);
        if (reg_wr && sel_cfg) begin
            s_d.ien = reg_wdata[CFG_EN_BIT];
            s_d.lvl = reg_wdata[CFG_LVL_LSB +: LVL_W];
        end
        if (reg_rd) s_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign reg_rdata = s_q.rdata;
    assign irq       = hit;
endmodule

// File: rtl/rx_window_buf_chk.sv
module rx_window_buf_chk #(
    parameter int PTR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             reg_wr,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             irq,
    input logic [PTR_W-1:0] fill,
    input logic             ovr,
    input logic             ien
);
    localparam logic [PTR_W-1:0] FULL_LVL = PTR_W'((1 << PTR_W) - 1);

    logic rel_wr, clr_wr, win_wr;
    assign rel_wr = reg_wr && (reg_addr == 12'h800);
    assign clr_wr = reg_wr && (reg_addr == 12'h000) && reg_wdata[16];
    assign win_wr = reg_wr && (reg_addr >= 12'h004) && (reg_addr < 12'h400);

    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (fill != FULL_LVL) && !rel_wr |=> fill == $past(fill) + 1'b1); // R2
    AST_WIN_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr && !in_valid |=> $stable(fill)); // R4
    AST_REL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        rel_wr && !in_valid && (reg_wdata >= 32'(fill)) |=> fill == '0); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (fill == FULL_LVL) && !rel_wr |=> ovr && (fill == FULL_LVL)); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !clr_wr |=> ovr); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq); // R9
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < PTR_W'(4)) |-> !irq); // R9
endmodule

bind rx_window_buf rx_window_buf_chk #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq       (irq),
    .fill      (fill_q),
    .ovr       (ovr_q),
    .ien       (ien_q)
);

// File: tb/rx_window_buf_tb.sv
module rx_window_buf_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #10 clk = ~clk;

    rx_window_buf u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_mem [1024];
    int m_w = 0, m_r = 0, m_fill = 0, m_lvl = 0;
    bit m_ovr = 0, m_ien = 0;

    function automatic bit exp_irq();
        return m_ien && (m_fill >= (4 << m_lvl));
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] v;
        int k;
        v = '0;
        if (a == 12'h000) begin
            v[31:24] = 8'(m_fill);
            v[7:6]   = 2'(m_fill >> 8);
            v[16]    = m_ovr;
            v[1]     = exp_irq();
        end else if (a >= 12'h004 && a < 12'h400) begin
            for (int i = 0; i < 4; i++) begin
                k = int'(a) - 4 + i;
                if (k < m_fill) v[8*i +: 8] = m_mem[(m_r + k) % 1024];
            end
        end else if (a == 12'h808) begin
            v[0]     = m_ien;
            v[22:20] = 3'(m_lvl);
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] d, input bit wr, input bit rd,
                        input logic [11:0] a, input logic [31:0] wd, input string req);
        logic [31:0] exp;
        int rel;
        bit full_old, clr;
        exp = exp_read(a);
        in_valid = v; in_data = d; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        @(negedge clk);
        in_valid = 0; reg_wr = 0; reg_rd = 0;
        rel = 0;
        if (wr && a == 12'h800) rel = (longint'(wd) > longint'(m_fill)) ? m_fill : int'(wd);
        full_old = (m_fill == 1023);
        clr = wr && a == 12'h000 && wd[16];
        if (v && !full_old) begin
            m_mem[m_w] = d;
            m_w = (m_w + 1) % 1024;
            m_fill++;
        end
        m_ovr = (m_ovr && !clr) || (v && full_old);
        m_r = (m_r + rel) % 1024;
        m_fill -= rel;
        if (wr && a == 12'h808) begin
            m_ien = wd[0];
            m_lvl = int'(wd[22:20]);
        end
        if (rd) check(reg_rdata == exp, req, reg_rdata, exp);
        check(irq == exp_irq(), "R9 irq", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        step(0, 0, 0, 1, a, 0, req);
    endtask
    task automatic wr(input logic [11:0] a, input logic [31:0] wd);
        step(0, 0, 1, 0, a, wd, "R8 write");
    endtask
    task automatic push(input logic [7:0] d);
        step(1, d, 0, 0, 0, 0, "R2 push");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(12'h000, "R1 status after reset");
        rd(12'h808, "R1 config after reset");
        // R8 configuration readback and unmapped read
        wr(12'h808, 32'h0050_0000);
        rd(12'h808, "R8 config readback");
        rd(12'h900, "R8 unmapped read");
        // R2 / R3 / R4
        for (int i = 0; i < 10; i++) push(8'(i * 7 + 3));
        rd(12'h000, "R2 fill in status");
        rd(12'h004, "R3 window word 0");
        rd(12'h008, "R3 window word 1");
        rd(12'h00C, "R4 lanes past fill zero");
        step(0, 0, 1, 0, 12'h004, 32'hDEAD_BEEF, "R4 window write");
        rd(12'h004, "R4 window write ignored");
        rd(12'h000, "R4 fill after window write");
        // R5 release and clamp
        wr(12'h800, 32'd3);
        rd(12'h004, "R5 window after release");
        wr(12'h800, 32'd100);
        rd(12'h000, "R5 clamped release");
        // R6 push and release in one cycle
        for (int i = 0; i < 5; i++) push(8'(8'hA0 + i));
        step(1, 8'h55, 1, 0, 12'h800, 32'd2, "R6 push with release");
        rd(12'h000, "R6 fill after overlap");
        rd(12'h004, "R6 window after overlap");
        // R9 level 0 threshold 4
        wr(12'h808, 32'h0000_0001);
        rd(12'h000, "R9 cause bit at threshold");
        wr(12'h800, 32'd1);
        rd(12'h000, "R9 cause below threshold");
        // R7 fill to capacity and beyond
        wr(12'h808, 32'h0070_0001);
        wr(12'h800, 32'd50);
        for (int i = 0; i < 1025; i++) push(8'($urandom));
        rd(12'h000, "R7 full with overrun");
        rd(12'h3FC, "R3 last window word");
        rd(12'h200, "R3 middle window word");
        wr(12'h000, 32'h0001_0000);
        rd(12'h000, "R7 overrun cleared");
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h000, "R5 huge release clamps to fill");
        // random mix
        for (int n = 0; n < 5000; n++) begin
            bit v;
            int op;
            logic [11:0] a;
            v  = ($urandom % 100) < 55;
            op = int'($urandom % 10);
            a  = 12'(4 + 4 * ($urandom % 255));
            case (op)
                0, 1, 2, 3: step(v, 8'($urandom), 0, 1, a, 0, "R3 random window read");
                4:          step(v, 8'($urandom), 0, 1, 12'h000, 0, "R2 random status read");
                5:          step(v, 8'($urandom), 1, 0, 12'h800, $urandom % (m_fill + 20), "R5 random release");
                6:          step(v, 8'($urandom), 1, 0, 12'h808, ($urandom & 32'h0070_0001), "R8 random config");
                7:          step(v, 8'($urandom), 1, 0, a, $urandom, "R4 random window write");
                8:          step(v, 8'($urandom), 1, 1, 12'h800, $urandom % (m_fill + 3), "R6 random overlap");
                default:    step(v, 8'($urandom), 0, 0, 0, 0, "R2 random idle");
            endcase
        end
        rd(12'h000, "R2 final status");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule